// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This combinational unit decides where instruction fetch goes two slots ahead in a 32-bit load/store processor that has one branch delay slot. It looks at the fetched instruction word, the address of that instruction and the two register operands already read for it. From these it produces the next-next program counter, a flag saying whether control flow was redirected, and a request to write a return address into the register file: an enable, a register index and the value.

It handles the conditional branches, which compare one register against zero or two registers against each other. It also handles the region jump, which keeps the top four address bits of the current PC and replaces the rest with a 26-bit word index. The third kind is the register-indirect jump. A small decoder turns the opcode, the rt field and the function field into a struct of selection strobes. A datapath module does the compares and builds the targets. Instructions that are not control transfers fall through to PC+8.

Top module: `npc_unit`

## Requirements
- R1: Opcode 6'b000100 is taken when rsVal equals rtVal, and opcode 6'b000101 is taken when they differ. A taken conditional branch gives nextPc = curPc + 4 + (sign-extended instr[15:0] << 2).
- R2: Opcode 6'b000110 is taken when rsVal, read as signed, is zero or negative. Opcode 6'b000111 is taken when rsVal is strictly positive.
- R3: Opcode 6'b000001 uses instr[20:16] to pick the condition. 5'b00000 and 5'b10000 are taken when rsVal is negative. 5'b00001 and 5'b10001 are taken when rsVal is zero or positive. Any other rt value is treated as a non-control instruction.
- R4: The regimm rt values 5'b10000 and 5'b10001 set linkWe with linkIdx = 31, whether or not the branch is taken.
- R5: Opcodes 6'b000010 and 6'b000011 are always taken, with nextPc = {curPc[31:28], instr[25:0], 2'b00}. Opcode 6'b000011 also sets linkWe with linkIdx = 31.
- R6: Opcode 6'b000000 with instr[5:0] = 6'b001000 is taken with nextPc = rsVal. With instr[5:0] = 6'b001001 it does the same and also sets linkWe with linkIdx = instr[15:11].
- R7: For a non-control instruction, nextPc = curPc + 8, taken = 0, linkWe = 0 and linkIdx = 0.
- R8: A conditional branch whose condition is false gives nextPc = curPc + 8 and taken = 0.
- R9: A branch offset with bit 15 set moves the target backwards. It is sign-extended over all 32 bits.
- R10: linkVal equals curPc + 8 for every instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Fetched instruction word |
| curPc | input | 32 | Address of that instruction |
| rsVal | input | 32 | Register operand selected by instr[25:21] |
| rtVal | input | 32 | Register operand selected by instr[20:16] |
| nextPc | output | 32 | Fetch address after the delay slot |
| taken | output | 1 | Control flow redirected |
| linkWe | output | 1 | Write return address to the register file |
| linkIdx | output | 5 | Register written with the return address |
| linkVal | output | 32 | Return address, curPc + 8 |

## Verification
The hardest case to reach from the ports is a linking regimm branch whose condition is false. Here the link write must still happen while nextPc stays on the fall-through path. The stimulus sets up this case by giving the link variants operands of the wrong sign. The signed compare edges are also tricky. The bench covers them with zero, 0x80000000 and all-ones operands, and uses a negative offset so that the sign extension is exercised.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam logic [5:0] OP_SPECIAL = 6'b000000;
  localparam logic [5:0] OP_REGIMM  = 6'b000001;
  localparam logic [5:0] OP_JREGION = 6'b000010;
  localparam logic [5:0] OP_JREGLNK = 6'b000011;
  localparam logic [5:0] OP_BRSAME  = 6'b000100;
  localparam logic [5:0] OP_BRDIFF  = 6'b000101;
  localparam logic [5:0] OP_BRNPOS  = 6'b000110;
  localparam logic [5:0] OP_BRPOS   = 6'b000111;

  localparam logic [5:0] FN_JIND    = 6'b001000;
  localparam logic [5:0] FN_JINDLNK = 6'b001001;

  localparam logic [4:0] RI_NEG     = 5'b00000;
  localparam logic [4:0] RI_NNEG    = 5'b00001;
  localparam logic [4:0] RI_NEGLNK  = 5'b10000;
  localparam logic [4:0] RI_NNEGLNK = 5'b10001;

  typedef struct packed {
    logic selEq;
    logic selNe;
    logic selLez;
    logic selGtz;
    logic selLtz;
    logic selGez;
    logic selRegion;
    logic selIndirect;
    logic linkOn;
    logic linkRd;
  } npcStrobes_t;
endpackage

// File: rtl/npc_ctrl.sv
module npc_ctrl
  import npc_pkg::*;
(
  input  logic [5:0]  opcode,
  input  logic [4:0]  rtField,
  input  logic [5:0]  funct,
  output npcStrobes_t strobes
);
  always_comb begin
    strobes = '0;
    unique case (opcode)
      OP_BRSAME: strobes.selEq  = 1'b1;
      OP_BRDIFF: strobes.selNe  = 1'b1;
      OP_BRNPOS: strobes.selLez = 1'b1;
      OP_BRPOS:  strobes.selGtz = 1'b1;
      OP_REGIMM: begin
        unique case (rtField)
          RI_NEG:     strobes.selLtz = 1'b1;
          RI_NNEG:    strobes.selGez = 1'b1;
          RI_NEGLNK:  begin strobes.selLtz = 1'b1; strobes.linkOn = 1'b1; end
          RI_NNEGLNK: begin strobes.selGez = 1'b1; strobes.linkOn = 1'b1; end
          default:    strobes = '0;
        endcase
      end
      OP_JREGION: strobes.selRegion = 1'b1;
      OP_JREGLNK: begin strobes.selRegion = 1'b1; strobes.linkOn = 1'b1; end
      OP_SPECIAL: begin
        if (funct == FN_JIND) begin
          strobes.selIndirect = 1'b1;
        end else if (funct == FN_JINDLNK) begin
          strobes.selIndirect = 1'b1;
          strobes.linkOn      = 1'b1;
          strobes.linkRd      = 1'b1;
        end
      end
      default: strobes = '0;
    endcase
  end
endmodule

// File: rtl/npc_dpath.sv
module npc_dpath
  import npc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int REGION_W = 4,
  parameter int OFF_W    = 16,
  parameter int IDX_W    = 5,
  parameter int LINK_REG = 31,
  localparam int JIDX_W  = ADDR_W - REGION_W - 2
) (
  input  npcStrobes_t         strobes,
  input  logic [ADDR_W-1:0]   curPc,
  input  logic [ADDR_W-1:0]   rsVal,
  input  logic [ADDR_W-1:0]   rtVal,
  input  logic [OFF_W-1:0]    offset,
  input  logic [JIDX_W-1:0]   jumpIdx,
  input  logic [IDX_W-1:0]    rdField,
  output logic [ADDR_W-1:0]   nextPc,
  output logic                taken,
  output logic                linkWe,
  output logic [IDX_W-1:0]    linkIdx,
  output logic [ADDR_W-1:0]   linkVal
);
  localparam int EXT_W = ADDR_W - OFF_W - 2;

  logic [ADDR_W-1:0] slotPc;
  logic [ADDR_W-1:0] seqPc;
  logic [ADDR_W-1:0] branchTgt;
  logic [ADDR_W-1:0] regionTgt;
  logic              rsNeg;
  logic              rsZero;
  logic              condHit;

  assign slotPc    = curPc + ADDR_W'(4);
  assign seqPc     = curPc + ADDR_W'(8);
  assign branchTgt = slotPc + {{EXT_W{offset[OFF_W-1]}}, offset, 2'b00};

  generate
    if (REGION_W > 0) begin : g_region
      assign regionTgt = {curPc[ADDR_W-1 -: REGION_W], jumpIdx, 2'b00};
    end else begin : g_flat
      assign regionTgt = {jumpIdx, 2'b00};
    end
  endgenerate

  assign rsNeg  = rsVal[ADDR_W-1];
  assign rsZero = (rsVal == '0);

  assign condHit = (strobes.selEq  &&  (rsVal == rtVal))
                 | (strobes.selNe  &&  (rsVal != rtVal))
                 | (strobes.selLez && (rsNeg || rsZero))
                 | (strobes.selGtz && !rsNeg && !rsZero)
                 | (strobes.selLtz &&  rsNeg)
                 | (strobes.selGez && !rsNeg);

  always_comb begin
    if (strobes.selIndirect) begin
      nextPc = rsVal;
      taken  = 1'b1;
    end else if (strobes.selRegion) begin
      nextPc = regionTgt;
      taken  = 1'b1;
    end else if (condHit) begin
      nextPc = branchTgt;
      taken  = 1'b1;
    end else begin
      nextPc = seqPc;
      taken  = 1'b0;
    end
  end

  always_comb begin
    linkWe  = strobes.linkOn;
    linkIdx = '0;
    if (strobes.linkOn) begin
      linkIdx = strobes.linkRd ? rdField : IDX_W'(LINK_REG);
    end
  end

  assign linkVal = seqPc;
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int REGION_W = 4,
  parameter int IDX_W    = 5,
  parameter int LINK_REG = 31
) (
  input  logic [ADDR_W-1:0] instr,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [ADDR_W-1:0] rsVal,
  input  logic [ADDR_W-1:0] rtVal,
  output logic [ADDR_W-1:0] nextPc,
  output logic              taken,
  output logic              linkWe,
  output logic [IDX_W-1:0]  linkIdx,
  output logic [ADDR_W-1:0] linkVal
);
  localparam int OFF_W  = 16;
  localparam int JIDX_W = ADDR_W - REGION_W - 2;

  npcStrobes_t strobes;

  npc_ctrl i_ctrl (
    .opcode  (instr[31:26]),
    .rtField (instr[20:16]),
    .funct   (instr[5:0]),
    .strobes (strobes)
  );

  npc_dpath #(
    .ADDR_W   (ADDR_W),
    .REGION_W (REGION_W),
    .OFF_W    (OFF_W),
    .IDX_W    (IDX_W),
    .LINK_REG (LINK_REG)
  ) i_dpath (
    .strobes (strobes),
    .curPc   (curPc),
    .rsVal   (rsVal),
    .rtVal   (rtVal),
    .offset  (instr[OFF_W-1:0]),
    .jumpIdx (instr[JIDX_W-1:0]),
    .rdField (instr[15:11]),
    .nextPc  (nextPc),
    .taken   (taken),
    .linkWe  (linkWe),
    .linkIdx (linkIdx),
    .linkVal (linkVal)
  );
endmodule

// File: rtl/npc_unit_checker.sv
module npc_unit_checker (
  input logic [31:0] instr,
  input logic [31:0] curPc,
  input logic [31:0] rsVal,
  input logic [31:0] nextPc,
  input logic        taken,
  input logic        linkWe,
  input logic [4:0]  linkIdx
);
  always_comb begin
    // R7 / R8: an untaken instruction falls through two slots
    a_r8_fallthrough: assert (taken || nextPc == curPc + 32'd8);
    // R7: no link index without a link write
    a_r7_idx_idle: assert (linkWe || linkIdx == 5'd0);
    // R4 / R5: non-register-format links target register 31
    a_r4_link_reg31: assert (!(linkWe && instr[31:26] != 6'b000000) || linkIdx == 5'd31);
    // R5: region jump keeps the top bits and is word aligned
    a_r5_region_keep: assert (!(instr[31:27] == 5'b00001)
                              || (taken && nextPc[31:28] == curPc[31:28] && nextPc[1:0] == 2'b00));
    // R6: indirect jump goes to rs
    a_r6_indirect: assert (!(taken && instr[31:26] == 6'b000000) || nextPc == rsVal);
    // R2: non-positive compare is signed
    a_r2_npos: assert (!(instr[31:26] == 6'b000110) || (taken == ($signed(rsVal) <= 0)));
  end
endmodule

bind npc_unit npc_unit_checker i_chk (
  .instr   (instr),
  .curPc   (curPc),
  .rsVal   (rsVal),
  .nextPc  (nextPc),
  .taken   (taken),
  .linkWe  (linkWe),
  .linkIdx (linkIdx)
);

// File: tb/test_npc_unit.sv
module test_npc_unit;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] instr, curPc, rsVal, rtVal;
  logic [31:0] nextPc, linkVal;
  logic        taken, linkWe;
  logic [4:0]  linkIdx;

  int checks = 0;
  int failures = 0;

  npc_unit i_npc_unit (
    .instr(instr), .curPc(curPc), .rsVal(rsVal), .rtVal(rtVal),
    .nextPc(nextPc), .taken(taken), .linkWe(linkWe),
    .linkIdx(linkIdx), .linkVal(linkVal)
  );

  function automatic logic [31:0] mkI(input logic [5:0] op, input logic [4:0] rs,
                                      input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] mkR(input logic [4:0] rs, input logic [4:0] rd,
                                      input logic [5:0] fn);
    return {6'b000000, rs, 5'd0, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] brTgt(input logic [31:0] pc, input logic [15:0] imm);
    logic [31:0] ext;
    ext = {{16{imm[15]}}, imm};
    return pc + 32'd4 + (ext << 2);
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] i, input logic [31:0] pc,
                       input logic [31:0] s, input logic [31:0] t);
    @(negedge clk);
    instr = i; curPc = pc; rsVal = s; rtVal = t;
    #1;
  endtask

  task automatic expect_out(input string req, input logic [31:0] np, input logic tk,
                            input logic lw, input logic [4:0] li);
    chk({req, " nextPc"}, nextPc, np);
    chk({req, " taken"}, {31'd0, taken}, {31'd0, tk});
    chk({req, " linkWe"}, {31'd0, linkWe}, {31'd0, lw});
    chk({req, " linkIdx"}, {27'd0, linkIdx}, {27'd0, li});
    chk({req, " linkVal R10"}, linkVal, curPc + 32'd8);
  endtask

  task automatic t_idle;
    apply(32'h0, 32'h0000_1000, 32'h5, 32'h5);
    expect_out("R7 nop", 32'h0000_1008, 1'b0, 1'b0, 5'd0);
    apply(mkI(6'b001000, 5'd1, 5'd2, 16'h0010), 32'h0000_2000, 32'h0, 32'h0);
    expect_out("R7 addi", 32'h0000_2008, 1'b0, 1'b0, 5'd0);
  endtask

  task automatic t_eq_ne;
    apply(mkI(6'b000100, 5'd1, 5'd2, 16'h0003), 32'h0040_0000, 32'h77, 32'h77);
    expect_out("R1 eq taken", brTgt(32'h0040_0000, 16'h0003), 1'b1, 1'b0, 5'd0);
    apply(mkI(6'b000100, 5'd1, 5'd2, 16'h0003), 32'h0040_0000, 32'h77, 32'h78);
    expect_out("R8 eq not", 32'h0040_0008, 1'b0, 1'b0, 5'd0);
    apply(mkI(6'b000101, 5'd1, 5'd2, 16'hFFFE), 32'h0040_0100, 32'h1, 32'h2);
    expect_out("R9 ne backward", 32'h0040_00FC, 1'b1, 1'b0, 5'd0);
    apply(mkI(6'b000101, 5'd1, 5'd2, 16'hFFFE), 32'h0040_0100, 32'h2, 32'h2);
    expect_out("R1 ne not", 32'h0040_0108, 1'b0, 1'b0, 5'd0);
  endtask

  task automatic t_zero_cmp;
    apply(mkI(6'b000110, 5'd3, 5'd0, 16'h0010), 32'h0000_0100, 32'h0, 32'h0);
    expect_out("R2 lez zero", brTgt(32'h100, 16'h0010), 1'b1, 1'b0, 5'd0);
    apply(mkI(6'b000110, 5'd3, 5'd0, 16'h0010), 32'h0000_0100, 32'h8000_0000, 32'h0);
    expect_out("R2 lez minneg", brTgt(32'h100, 16'h0010), 1'b1, 1'b0, 5'd0);
    apply(mkI(6'b000110, 5'd3, 5'd0, 16'h0010), 32'h0000_0100, 32'h1, 32'h0);
    expect_out("R2 lez pos", 32'h108, 1'b0, 1'b0, 5'd0);
    apply(mkI(6'b000111, 5'd3, 5'd0, 16'h8000), 32'h0010_0000, 32'h1, 32'h0);
    expect_out("R2 gtz pos R9", brTgt(32'h0010_0000, 16'h8000), 1'b1, 1'b0, 5'd0);
    apply(mkI(6'b000111, 5'd3, 5'd0, 16'h0004), 32'h0010_0000, 32'hFFFF_FFFF, 32'h0);
    expect_out("R2 gtz neg", 32'h0010_0008, 1'b0, 1'b0, 5'd0);
    apply(mkI(6'b000111, 5'd3, 5'd0, 16'h0004), 32'h0010_0000, 32'h0, 32'h0);
    expect_out("R2 gtz zero", 32'h0010_0008, 1'b0, 1'b0, 5'd0);
  endtask

  task automatic t_regimm;
    apply(mkI(6'b000001, 5'd4, 5'b00000, 16'h0020), 32'h0000_4000, 32'hFFFF_FFFB, 32'h0);
    expect_out("R3 ltz neg", brTgt(32'h4000, 16'h0020), 1'b1, 1'b0, 5'd0);
    apply(mkI(6'b000001, 5'd4, 5'b00000, 16'h0020), 32'h0000_4000, 32'h0, 32'h0);
    expect_out("R3 ltz zero", 32'h4008, 1'b0, 1'b0, 5'd0);
    apply(mkI(6'b000001, 5'd4, 5'b00001, 16'h0020), 32'h0000_4000, 32'h0, 32'h0);
    expect_out("R3 gez zero", brTgt(32'h4000, 16'h0020), 1'b1, 1'b0, 5'd0);
    apply(mkI(6'b000001, 5'd4, 5'b10000, 16'h0020), 32'h0000_4000, 32'h5, 32'h0);
    expect_out("R4 ltzal not taken", 32'h4008, 1'b0, 1'b1, 5'd31);
    apply(mkI(6'b000001, 5'd4, 5'b10000, 16'h0020), 32'h0000_4000, 32'h8000_0001, 32'h0);
    expect_out("R4 ltzal taken", brTgt(32'h4000, 16'h0020), 1'b1, 1'b1, 5'd31);
    apply(mkI(6'b000001, 5'd4, 5'b10001, 16'hFFF0), 32'h0000_4000, 32'h5, 32'h0);
    expect_out("R4 gezal taken", brTgt(32'h4000, 16'hFFF0), 1'b1, 1'b1, 5'd31);
    apply(mkI(6'b000001, 5'd4, 5'b10001, 16'hFFF0), 32'h0000_4000, 32'hFFFF_FFFF, 32'h0);
    expect_out("R4 gezal not taken", 32'h4008, 1'b0, 1'b1, 5'd31);
    apply(mkI(6'b000001, 5'd4, 5'b00010, 16'h0020), 32'h0000_4000, 32'h0, 32'h0);
    expect_out("R3 other rt", 32'h4008, 1'b0, 1'b0, 5'd0);
  endtask

  task automatic t_region;
    logic [25:0] idx;
    idx = 26'h012_3456;
    apply({6'b000010, idx}, 32'hA000_0010, 32'h0, 32'h0);
    expect_out("R5 jump", {4'hA, idx, 2'b00}, 1'b1, 1'b0, 5'd0);
    apply({6'b000011, 26'h3FF_FFFF}, 32'h5FFF_FFF0, 32'h0, 32'h0);
    expect_out("R5 jump link", 32'h5FFF_FFFC, 1'b1, 1'b1, 5'd31);
  endtask

  task automatic t_indirect;
    apply(mkR(5'd9, 5'd0, 6'b001000), 32'h0000_8000, 32'h1234_5678, 32'h0);
    expect_out("R6 jr", 32'h1234_5678, 1'b1, 1'b0, 5'd0);
    apply(mkR(5'd9, 5'd7, 6'b001001), 32'h0000_8000, 32'hCAFE_0000, 32'h0);
    expect_out("R6 jalr", 32'hCAFE_0000, 1'b1, 1'b1, 5'd7);
    apply(mkR(5'd9, 5'd7, 6'b100001), 32'h0000_8000, 32'hCAFE_0000, 32'h0);
    expect_out("R7 addu", 32'h0000_8008, 1'b0, 1'b0, 5'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired got=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    instr = '0; curPc = '0; rsVal = '0; rtVal = '0;
    repeat (2) @(posedge clk);
    t_idle();
    t_eq_ne();
    t_zero_cmp();
    t_regimm();
    t_region();
    t_indirect();
    repeat (2) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule